// File: doc/BRIEF.md
# Standby Power-Mode Sequencer

This block is the power-mode state machine of a small microcontroller. When the CPU executes its sleep instruction, the block receives a one-cycle strobe. It then chooses between a deep standby state and a lighter sleep state. The choice depends on three configuration bits that must all agree. In deep standby the oscillator is stopped, the chip clock is withheld, the CPU is halted and the I/O ports are told to float.

A qualified interrupt ends standby. The oscillator restarts first. The chip clock stays off for a selectable number of reference ticks while the oscillator settles. The block then releases the clock, resumes at high or medium speed, and pulses a strobe that starts interrupt exception handling. An interrupt is qualified only when the global mask is clear and the source is both pending and enabled.

The reset pin is asserted asynchronously from any state and overrides every other transition. The oscillator restarts at once while the pin is low. After the pin is released, the block waits two synchronizer cycles and then the longest settling time. Only then does it pulse the reset-exception strobe. If the standby conditions are not met, a sleep strobe leads to the sleep state instead. From sleep, a qualified interrupt returns the block to active mode in one cycle, with no settling wait.

Top module: `pm_standby_ctrl`

## Requirements
- R1: In active mode (clk_run=1, cpu_halt=0), a sleep_stb with cfg_deep_sel=1, cfg_subclk_on=0 and cfg_timer_mode=0 moves the block to standby in the next cycle.
- R2: In standby: osc_on=0, clk_run=0, cpu_halt=1, io_hiz=1 and med_sel=0.
- R3: In standby, a qualified interrupt sets osc_on=1 in the next cycle while clk_run stays 0 and io_hiz stays 1. After L = SETTLE_BASE << cfg_settle_sel counted ticks, clk_run=1, io_hiz=0 and cpu_halt=0, and irq_exc_stb pulses in that same cycle. With ref_tick held at 1, clk_run rises L+1 cycles after the edge at which the interrupt is first seen. cfg_settle_sel is captured when the wait starts.
- R4: After a standby wake, med_sel equals the cfg_wake_med value sampled on the cycle the wait ends. In active and sleep modes, med_rate equals cfg_med_div (followed live) when med_sel=1, and 0 otherwise. Sleep keeps the current med_sel.
- R5: A wake is qualified only when imask=0 and (irq_req & irq_en) is nonzero. Otherwise standby and sleep are both kept.
- R6: The settling wait advances only on cycles with ref_tick=1. While ref_tick=0, clk_run stays 0, and it rises right after the L-th tick.
- R7: While res_n=0, the outputs are osc_on=1, clk_run=1, cpu_halt=1, io_hiz=0 and no strobes, taking effect without waiting for a clock edge and from any state. After res_n rises, rst_exc_stb pulses 2 + SETTLE_BASE·2^(2^SEL_W−1) cycles later, counted with ref_tick=1. In the same cycle cpu_halt falls and med_sel=0.
- R8: A sleep_stb in active mode without all three R1 conditions enters sleep: osc_on=1, clk_run=1, cpu_halt=1, io_hiz=0. A qualified interrupt then gives cpu_halt=0 and an irq_exc_stb pulse in the next cycle.
- R9: irq_exc_stb and rst_exc_stb are single-cycle pulses and never high together.
- R10: A sleep_stb outside active mode (in sleep, or during a settling wait) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| res_n | input | 1 | Reset pin, active low, asynchronous assert |
| ref_tick | input | 1 | Free-running reference tick for settling |
| sleep_stb | input | 1 | One-cycle sleep-instruction strobe |
| cfg_deep_sel | input | 1 | Selects standby on sleep |
| cfg_subclk_on | input | 1 | Low-speed clock in use (blocks standby) |
| cfg_timer_mode | input | 1 | Timer-mode bit (blocks standby) |
| cfg_wake_med | input | 1 | Resume at medium speed after standby |
| cfg_settle_sel | input | SEL_W | Settling-time select |
| cfg_med_div | input | DIV_W | Medium-speed rate select |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Per-source enables |
| imask | input | 1 | Global interrupt mask |
| osc_on | output | 1 | Oscillator run request |
| clk_run | output | 1 | Chip clock enable |
| med_sel | output | 1 | Medium-speed clock selected |
| med_rate | output | DIV_W | Medium-speed rate in use |
| io_hiz | output | 1 | I/O high-impedance request |
| cpu_halt | output | 1 | CPU halt |
| irq_exc_stb | output | 1 | Interrupt exception start pulse |
| rst_exc_stb | output | 1 | Reset exception start pulse |

## Verification
The bench builds the block with N_IRQ=4, SETTLE_BASE=4 and SEL_W=3. With these values the longest wait is 512 ticks, so every one of the eight settling selects can be timed to the exact cycle, along with the reset wait. The small source count allows a full sweep of mask, enable and request combinations: all 512 in standby, plus a request pattern against every enable in sleep. The bench also sweeps all eight combinations of the three standby conditions and tests tick gating with sparse ticks.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [2:0] {
        PM_RST_SETTLE  = 3'd0,
        PM_ACTIVE      = 3'd1,
        PM_SLEEP       = 3'd2,
        PM_STANDBY     = 3'd3,
        PM_WAKE_SETTLE = 3'd4
    } pm_state_e;

    typedef struct packed {
        pm_state_e state;
        logic      med;
        logic      irq_stb;
        logic      rst_stb;
    } pm_regs_t;

endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    logic [1:0] sync_q;
    logic [1:0] sync_d;

    always_comb begin
        sync_d = {sync_q[0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= 2'b00;
        else         sync_q <= sync_d;
    end

    assign rst_n_o = sync_q[1];
endmodule

// File: rtl/pm_wake_detect.sv
module pm_wake_detect #(
    parameter int N_IRQ = 4
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             imask,
    output logic             wake_o
);
    logic [N_IRQ-1:0] hit;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_src
        assign hit[i] = irq_req[i] & irq_en[i];
    end

    assign wake_o = ~imask & (|hit);
endmodule

// File: rtl/pm_settle_timer.sv
module pm_settle_timer #(
    parameter int SETTLE_BASE = 8,
    parameter int SEL_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             done_o
);
    localparam int MAX_SHIFT = (1 << SEL_W) - 1;
    localparam int MAX_LIM   = SETTLE_BASE << MAX_SHIFT;
    localparam int CNT_W     = $clog2(MAX_LIM) + 1;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SEL_W-1:0] sel_q, sel_d;
    logic [CNT_W-1:0] lim;

    assign lim    = CNT_W'(SETTLE_BASE) << sel_q;
    assign done_o = run_i & tick_i & (cnt_q == (lim - CNT_W'(1)));

    always_comb begin
        cnt_d = cnt_q;
        sel_d = sel_q;
        if (start_i) begin
            cnt_d = '0;
            sel_d = sel_i;
        end else if (run_i && tick_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    // After reset the slowest setting is used: configuration is unknown then.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= '1;
        end else begin
            cnt_q <= cnt_d;
            sel_q <= sel_d;
        end
    end
endmodule

// File: rtl/pm_standby_ctrl.sv
module pm_standby_ctrl
    import pm_pkg::*;
#(
    parameter int N_IRQ       = 4,
    parameter int SETTLE_BASE = 8,
    parameter int SEL_W       = 3,
    parameter int DIV_W       = 2
) (
    input  logic             clk,
    input  logic             res_n,
    input  logic             ref_tick,
    input  logic             sleep_stb,
    input  logic             cfg_deep_sel,
    input  logic             cfg_subclk_on,
    input  logic             cfg_timer_mode,
    input  logic             cfg_wake_med,
    input  logic [SEL_W-1:0] cfg_settle_sel,
    input  logic [DIV_W-1:0] cfg_med_div,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             imask,
    output logic             osc_on,
    output logic             clk_run,
    output logic             med_sel,
    output logic [DIV_W-1:0] med_rate,
    output logic             io_hiz,
    output logic             cpu_halt,
    output logic             irq_exc_stb,
    output logic             rst_exc_stb
);
    localparam pm_regs_t REGS_RST = '{state: PM_RST_SETTLE, med: 1'b0,
                                      irq_stb: 1'b0, rst_stb: 1'b0};

    logic     rst_n_s;
    logic     wake_req;
    logic     deep_ok;
    logic     tmr_start, tmr_run, tmr_done;
    pm_regs_t r_q, r_d;

    pm_rst_sync u_rst (
        .clk     (clk),
        .arst_n  (res_n),
        .rst_n_o (rst_n_s)
    );

    pm_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .imask   (imask),
        .wake_o  (wake_req)
    );

    pm_settle_timer #(.SETTLE_BASE(SETTLE_BASE), .SEL_W(SEL_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n_s),
        .start_i (tmr_start),
        .run_i   (tmr_run),
        .tick_i  (ref_tick),
        .sel_i   (cfg_settle_sel),
        .done_o  (tmr_done)
    );

    assign deep_ok = cfg_deep_sel & ~cfg_subclk_on & ~cfg_timer_mode;
    assign tmr_run = (r_q.state == PM_RST_SETTLE) || (r_q.state == PM_WAKE_SETTLE);

    always_comb begin
        r_d         = r_q;
        r_d.irq_stb = 1'b0;
        r_d.rst_stb = 1'b0;
        tmr_start   = 1'b0;
        case (r_q.state)
            PM_RST_SETTLE: begin
                if (tmr_done) begin
                    r_d.state   = PM_ACTIVE;
                    r_d.med     = 1'b0;
                    r_d.rst_stb = 1'b1;
                end
            end
            PM_ACTIVE: begin
                if (sleep_stb) begin
                    r_d.state = deep_ok ? PM_STANDBY : PM_SLEEP;
                end
            end
            PM_SLEEP: begin
                if (wake_req) begin
                    r_d.state   = PM_ACTIVE;
                    r_d.irq_stb = 1'b1;
                end
            end
            PM_STANDBY: begin
                if (wake_req) begin
                    r_d.state = PM_WAKE_SETTLE;
                    tmr_start = 1'b1;
                end
            end
            PM_WAKE_SETTLE: begin
                if (tmr_done) begin
                    r_d.state   = PM_ACTIVE;
                    r_d.med     = cfg_wake_med;
                    r_d.irq_stb = 1'b1;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n_s) begin
        if (!rst_n_s) r_q <= REGS_RST;
        else          r_q <= r_d;
    end

    always_comb begin
        osc_on   = 1'b1;
        clk_run  = 1'b1;
        cpu_halt = 1'b1;
        io_hiz   = 1'b0;
        med_sel  = 1'b0;
        case (r_q.state)
            PM_ACTIVE: begin
                cpu_halt = 1'b0;
                med_sel  = r_q.med;
            end
            PM_SLEEP: begin
                med_sel  = r_q.med;
            end
            PM_STANDBY: begin
                osc_on   = 1'b0;
                clk_run  = 1'b0;
                io_hiz   = 1'b1;
            end
            PM_WAKE_SETTLE: begin
                clk_run  = 1'b0;
                io_hiz   = 1'b1;
            end
            default: ;
        endcase
        med_rate = med_sel ? cfg_med_div : '0;
    end

    assign irq_exc_stb = r_q.irq_stb;
    assign rst_exc_stb = r_q.rst_stb;
endmodule

// File: rtl/pm_standby_ctrl_chk.sv
module pm_standby_ctrl_chk #(
    parameter int N_IRQ = 4
) (
    input logic             clk,
    input logic             res_n,
    input logic             ref_tick,
    input logic             sleep_stb,
    input logic             cfg_deep_sel,
    input logic             cfg_subclk_on,
    input logic             cfg_timer_mode,
    input logic             cfg_wake_med,
    input logic [N_IRQ-1:0] irq_req,
    input logic [N_IRQ-1:0] irq_en,
    input logic             imask,
    input logic             osc_on,
    input logic             clk_run,
    input logic             med_sel,
    input logic             io_hiz,
    input logic             cpu_halt,
    input logic             irq_exc_stb,
    input logic             rst_exc_stb
);
    a_r1_standby_entry: assert property (@(posedge clk) disable iff (!res_n)
        (clk_run && !cpu_halt && sleep_stb && cfg_deep_sel && !cfg_subclk_on && !cfg_timer_mode)
        |=> (!osc_on && io_hiz));

    a_r2_standby_outputs: assert property (@(posedge clk) disable iff (!res_n)
        !osc_on |-> (!clk_run && cpu_halt && io_hiz && !med_sel));

    a_r3_wake_starts_osc: assert property (@(posedge clk) disable iff (!res_n)
        (!osc_on && !imask && (|(irq_req & irq_en))) |=> (osc_on && !clk_run && io_hiz));

    a_r4_resume_speed: assert property (@(posedge clk) disable iff (!res_n)
        (irq_exc_stb && $past(io_hiz)) |-> (med_sel == $past(cfg_wake_med)));

    a_r5_mask_holds: assert property (@(posedge clk) disable iff (!res_n)
        (!osc_on && (imask || !(|(irq_req & irq_en)))) |=> !osc_on);

    a_r6_settle_needs_tick: assert property (@(posedge clk) disable iff (!res_n)
        (osc_on && !clk_run && !ref_tick) |=> !clk_run);

    a_r7_reset_outputs: assert property (@(posedge clk)
        !res_n |-> (osc_on && clk_run && cpu_halt && !io_hiz && !irq_exc_stb && !rst_exc_stb));

    a_r8_sleep_entry: assert property (@(posedge clk) disable iff (!res_n)
        (clk_run && !cpu_halt && sleep_stb && !(cfg_deep_sel && !cfg_subclk_on && !cfg_timer_mode))
        |=> (clk_run && cpu_halt && !io_hiz));

    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!res_n)
        !(irq_exc_stb && rst_exc_stb));

    a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!res_n)
        irq_exc_stb |=> !irq_exc_stb);

    a_r9_rst_pulse: assert property (@(posedge clk) disable iff (!res_n)
        rst_exc_stb |=> !rst_exc_stb);

    a_r10_sleep_ignored: assert property (@(posedge clk) disable iff (!res_n)
        (clk_run && cpu_halt && !io_hiz && sleep_stb && !rst_exc_stb) |=> osc_on);
endmodule

bind pm_standby_ctrl pm_standby_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk            (clk),
    .res_n          (res_n),
    .ref_tick       (ref_tick),
    .sleep_stb      (sleep_stb),
    .cfg_deep_sel   (cfg_deep_sel),
    .cfg_subclk_on  (cfg_subclk_on),
    .cfg_timer_mode (cfg_timer_mode),
    .cfg_wake_med   (cfg_wake_med),
    .irq_req        (irq_req),
    .irq_en         (irq_en),
    .imask          (imask),
    .osc_on         (osc_on),
    .clk_run        (clk_run),
    .med_sel        (med_sel),
    .io_hiz         (io_hiz),
    .cpu_halt       (cpu_halt),
    .irq_exc_stb    (irq_exc_stb),
    .rst_exc_stb    (rst_exc_stb)
);

// File: tb/sim_pm_standby_ctrl.sv
module sim_pm_standby_ctrl;
    localparam int N     = 4;
    localparam int BASE  = 4;
    localparam int SEL_W = 3;
    localparam int DIV_W = 2;
    localparam int LMAX  = BASE << ((1 << SEL_W) - 1);

    logic clk = 1'b0;
    logic res_n, ref_tick, sleep_stb;
    logic cfg_deep_sel, cfg_subclk_on, cfg_timer_mode, cfg_wake_med;
    logic [SEL_W-1:0] cfg_settle_sel;
    logic [DIV_W-1:0] cfg_med_div;
    logic [N-1:0] irq_req, irq_en;
    logic imask;
    logic osc_on, clk_run, med_sel, io_hiz, cpu_halt, irq_exc_stb, rst_exc_stb;
    logic [DIV_W-1:0] med_rate;

    int checks = 0;
    int errors = 0;

    pm_standby_ctrl #(.N_IRQ(N), .SETTLE_BASE(BASE), .SEL_W(SEL_W), .DIV_W(DIV_W)) u0 (
        .clk(clk), .res_n(res_n), .ref_tick(ref_tick), .sleep_stb(sleep_stb),
        .cfg_deep_sel(cfg_deep_sel), .cfg_subclk_on(cfg_subclk_on),
        .cfg_timer_mode(cfg_timer_mode), .cfg_wake_med(cfg_wake_med),
        .cfg_settle_sel(cfg_settle_sel), .cfg_med_div(cfg_med_div),
        .irq_req(irq_req), .irq_en(irq_en), .imask(imask),
        .osc_on(osc_on), .clk_run(clk_run), .med_sel(med_sel), .med_rate(med_rate),
        .io_hiz(io_hiz), .cpu_halt(cpu_halt),
        .irq_exc_stb(irq_exc_stb), .rst_exc_stb(rst_exc_stb)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic release_reset();
        int n = 0;
        res_n = 1'b1;
        while (n < 3000) begin
            @(negedge clk);
            n++;
            if (rst_exc_stb) break;
        end
        chk("R7 reset wait cycles", n, LMAX + 2);
        chk("R7 cpu runs at reset strobe", cpu_halt, 0);
        chk("R7 high speed after reset", med_sel, 0);
        @(negedge clk);
        chk("R9 reset strobe one cycle", rst_exc_stb, 0);
    endtask

    task automatic go_standby();
        cfg_deep_sel = 1'b1; cfg_subclk_on = 1'b0; cfg_timer_mode = 1'b0;
        sleep_stb = 1'b1;
        @(negedge clk);
        sleep_stb = 1'b0;
    endtask

    task automatic wait_active();
        for (int i = 0; i < 2000; i++) begin
            if (clk_run && !cpu_halt) break;
            @(negedge clk);
        end
    endtask

    task automatic wake_all();
        imask = 1'b0; irq_en = '1; irq_req = '1;
    endtask

    task automatic clear_irq();
        irq_req = '0; irq_en = '0; imask = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        res_n = 1'b0; ref_tick = 1'b1; sleep_stb = 1'b0;
        cfg_deep_sel = 1'b0; cfg_subclk_on = 1'b0; cfg_timer_mode = 1'b0;
        cfg_wake_med = 1'b0; cfg_settle_sel = '0; cfg_med_div = '0;
        irq_req = '0; irq_en = '0; imask = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 osc on in reset", osc_on, 1);
        chk("R7 clk on in reset", clk_run, 1);
        chk("R7 halt in reset", cpu_halt, 1);
        chk("R7 no hiz in reset", io_hiz, 0);
        chk("R7 no strobes in reset", int'(irq_exc_stb) + int'(rst_exc_stb), 0);
        release_reset();

        // R1 / R8: all combinations of the three standby conditions
        for (int c = 0; c < 8; c++) begin
            bit deep;
            deep = (c == 1);
            cfg_deep_sel = c[0]; cfg_subclk_on = c[1]; cfg_timer_mode = c[2];
            sleep_stb = 1'b1;
            @(negedge clk);
            sleep_stb = 1'b0;
            if (deep) begin
                chk("R1 standby entered", osc_on, 0);
                chk("R2 clk off in standby", clk_run, 0);
                chk("R2 hiz in standby", io_hiz, 1);
                chk("R2 halt in standby", cpu_halt, 1);
                chk("R2 normal speed flag in standby", med_sel, 0);
                wake_all();
                wait_active();
            end else begin
                chk("R8 sleep osc on", osc_on, 1);
                chk("R8 sleep clk on", clk_run, 1);
                chk("R8 sleep halt", cpu_halt, 1);
                chk("R8 sleep no hiz", io_hiz, 0);
                wake_all();
                @(negedge clk);
                chk("R8 sleep wake in one cycle", cpu_halt, 0);
                chk("R8 sleep wake strobe", irq_exc_stb, 1);
                @(negedge clk);
                chk("R9 irq strobe one cycle", irq_exc_stb, 0);
            end
            clear_irq();
            @(negedge clk);
        end

        // R3 / R4: every settling select, exact wait
        for (int s = 0; s < 8; s++) begin
            int n;
            int lim;
            bit bad;
            lim = BASE << s;
            cfg_settle_sel = 3'(s);
            cfg_wake_med = s[0];
            cfg_med_div = 2'(s);
            go_standby();
            cfg_settle_sel = 3'(7 - s);   // captured value must be the old one
            cfg_settle_sel = 3'(s);
            wake_all();
            n = 0;
            bad = 1'b0;
            while (n < 3000) begin
                @(negedge clk);
                n++;
                if (clk_run) break;
                if (!osc_on || !io_hiz) bad = 1'b1;
            end
            chk("R3 settle cycles", n, lim + 1);
            chk("R3 osc on and hiz held during settle", bad, 0);
            chk("R3 wake strobe", irq_exc_stb, 1);
            chk("R3 hiz released", io_hiz, 0);
            chk("R3 cpu runs", cpu_halt, 0);
            chk("R4 resume speed", med_sel, s[0]);
            chk("R4 rate", med_rate, s[0] ? (s & 3) : 0);
            clear_irq();
            @(negedge clk);
            chk("R9 irq strobe one cycle", irq_exc_stb, 0);
        end

        // R4: sleep keeps medium speed (last wake was medium) and follows the rate live
        cfg_deep_sel = 1'b0; sleep_stb = 1'b1; cfg_med_div = 2'd1;
        @(negedge clk);
        sleep_stb = 1'b0;
        chk("R4 sleep keeps medium", med_sel, 1);
        chk("R4 sleep rate", med_rate, 1);
        cfg_med_div = 2'd2;
        #1;
        chk("R4 sleep rate live", med_rate, 2);
        // R10: strobe in sleep is ignored
        cfg_deep_sel = 1'b1; sleep_stb = 1'b1;
        @(negedge clk);
        sleep_stb = 1'b0;
        chk("R10 sleep strobe ignored osc", osc_on, 1);
        chk("R10 sleep strobe ignored hiz", io_hiz, 0);
        chk("R10 still sleeping", cpu_halt, 1);

        // R5 in sleep: request pattern 1010 against every enable and mask
        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 16; e++) begin
                bit exp_wake;
                if (!cpu_halt) begin
                    cfg_deep_sel = 1'b0; sleep_stb = 1'b1;
                    @(negedge clk);
                    sleep_stb = 1'b0;
                end
                exp_wake = (m == 0) && ((e & 4'b1010) != 0);
                imask = m[0]; irq_en = 4'(e); irq_req = 4'b1010;
                @(negedge clk);
                chk("R5 sleep wake qualification", !cpu_halt, exp_wake);
                clear_irq();
                @(negedge clk);
            end
        end
        if (cpu_halt) begin
            wake_all();
            @(negedge clk);
            clear_irq();
            @(negedge clk);
        end
        chk("R5 back to active", cpu_halt, 0);
        cfg_med_div = 2'd0;

        // R5 in standby: full mask x enable x request sweep
        cfg_settle_sel = '0;
        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 16; e++) begin
                for (int q = 0; q < 16; q++) begin
                    bit exp_wake;
                    go_standby();
                    exp_wake = (m == 0) && ((e & q) != 0);
                    imask = m[0]; irq_en = 4'(e); irq_req = 4'(q);
                    repeat (3) @(negedge clk);
                    chk("R5 standby wake qualification", osc_on, exp_wake);
                    if (!exp_wake) wake_all();
                    wait_active();
                    clear_irq();
                    @(negedge clk);
                end
            end
        end

        // R6 / R10: settling advances only on ticks; strobe during settle ignored
        cfg_settle_sel = 3'd1;
        go_standby();
        ref_tick = 1'b0;
        wake_all();
        repeat (100) @(negedge clk);
        chk("R6 no tick no release", clk_run, 0);
        chk("R6 osc running", osc_on, 1);
        sleep_stb = 1'b1;
        @(negedge clk);
        sleep_stb = 1'b0;
        chk("R10 settle strobe ignored clk", clk_run, 0);
        chk("R10 settle strobe ignored osc", osc_on, 1);
        begin
            int ticks = 0;
            int early = 0;
            for (int k = 0; k < 20; k++) begin
                ref_tick = 1'b1;
                @(negedge clk);
                ref_tick = 1'b0;
                ticks++;
                if (clk_run) break;
                @(negedge clk);
                if (clk_run) early++;
                @(negedge clk);
            end
            chk("R6 ticks to release", ticks, BASE << 1);
            chk("R6 no release between ticks", early, 0);
        end
        ref_tick = 1'b1;
        clear_irq();
        @(negedge clk);

        // R7: reset arriving in standby acts without a clock edge
        go_standby();
        chk("R2 in standby before reset", osc_on, 0);
        #2;
        res_n = 1'b0;
        #1;
        chk("R7 async osc on", osc_on, 1);
        chk("R7 async clk on", clk_run, 1);
        chk("R7 async hiz off", io_hiz, 0);
        chk("R7 async halt", cpu_halt, 1);
        repeat (4) @(negedge clk);
        chk("R7 no reset strobe while low", rst_exc_stb, 0);
        release_reset();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule